// File: doc/BRIEF.md
# Composite Memory Enable Generator

This block drives one enable line for a field memory, either a write enable or a read enable. It counts pixel clocks from each rising edge of a line reference to build a horizontal window, and counts lines from each rising edge of a field reference to build a vertical window. The enable is high only where both windows are open.

The horizontal edges are set by a coarse index and a granularity of either 2 or 4 clocks, plus a fine delay of 0 to 3 clocks. The vertical edges are set as line indices. On top of the window logic sit three overrides. A still-picture control holds the enable low. A progressive-scan control blanks every second field. An external mode passes a sampled external enable through and ignores all window settings.

All settings are static configuration inputs, and the line limits for 50 Hz or 60 Hz operation are supplied as inputs. The output is one register. Its value after a clock edge reflects the counter state after that same edge.

Top module: `comp_enable_gen`

## Requirements
- R1: While reset is high, and in the cycle that reset is sampled, `mem_en` is 0. The progressive-scan field flag resets to the enabled field.
- R2: The clock position k counts the edges since the edge that first saw `line_ref` high after it was low. That edge is k = 0. With `step4` = 0 and fine delay 0, `mem_en` is high for k in [2*Nr+2, 2*Nf+2), provided the vertical window is open and no override is active.
- R3: With `step4` = 1 and fine delay 0, the horizontal window covers k in [4*Nr+4, 4*Nf+4).
- R4: `h_fine` (0 to 3) adds that many clocks to both horizontal edges, in either step mode.
- R5: When Nr > Nf, the horizontal window wraps around the line reference. It is open for k >= rise position or k < fall position.
- R6: The horizontal window stays closed when Nr = Nf, Nr >= `h_nmax`, Nf = 0, or Nf > `h_nmax`.
- R7: The line index L is 0 in the line whose reference rise coincides with the `field_ref` rise. L increments on each later `line_ref` rise. When 1 <= Nr < Nf <= `v_nmax`, the vertical window is open for Nr <= L < Nf.
- R8: The vertical window stays closed when Nr < 1, Nr >= `v_nmax`, Nf <= 1, Nf > `v_nmax`, or Nr >= Nf.
- R9: With `still_en` = 1, `mem_en` is 0 after the next edge. This holds whatever the other modes and settings are.
- R10: A field flag toggles on each `field_ref` rising edge. With `prog_en` = 1, `mem_en` is 0 in every field where the flag is set. The flag is set in the first field after the first field reference following reset, and in every second field after that.
- R11: With `ext_en` = 1 and `still_en` = 0, `mem_en` equals the `ext_we` value sampled at the previous edge. The horizontal, vertical and fine settings have no effect in this mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| line_ref | input | 1 | Line reference; its rising edge restarts the clock count |
| field_ref | input | 1 | Field reference; its rising edge restarts the line count |
| step4 | input | 1 | 0: 2-clock granularity, 1: 4-clock granularity |
| h_nmax | input | 9 | Upper limit for horizontal indices |
| h_rise_n | input | 9 | Horizontal rising-edge index Nr |
| h_fall_n | input | 9 | Horizontal falling-edge index Nf |
| h_fine | input | 2 | Extra clocks added to both horizontal edges |
| v_nmax | input | 9 | Upper limit for vertical indices (lines per field limit) |
| v_rise_n | input | 9 | Vertical rising-edge line Nr |
| v_fall_n | input | 9 | Vertical falling-edge line Nf |
| still_en | input | 1 | Force the enable low |
| prog_en | input | 1 | Blank every second field |
| ext_en | input | 1 | Pass the sampled external enable through |
| ext_we | input | 1 | External enable input |
| mem_en | output | 1 | Composite enable, registered |

## Verification
The assertions take for granted that the reference inputs are synchronous to the pixel clock. They also assume that a field reference rise lands on the same clock as a line reference rise, so the counters restart together. The horizontal counter must never reach saturation within a line, and the configuration must change only between measured stretches. The stimulus generates both references from one cycle counter, with a short fixed line and a field of a few lines. It changes settings only between clock edges. It sweeps every combination of step, indices around the limit, and fine delay. It then sweeps every vertical index pair, the overrides, and an irregular external enable pattern.

// File: rtl/ceg_pkg.sv
`timescale 1ns/1ps
package ceg_pkg;

  // Which source drives the composite enable register next.
  typedef enum logic [1:0] {
    SRC_WINDOW = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_OFF    = 2'd2
  } en_src_e;

endpackage

// File: rtl/ceg_hpos.sv
`timescale 1ns/1ps
// Edge position = step*N + step + fine, computed with shifts.
module ceg_hpos #(
  parameter int N_W    = 9,
  parameter int FINE_W = 2,
  parameter int POS_W  = 12
) (
  input  logic [N_W-1:0]    n_idx,
  input  logic              step4,
  input  logic [FINE_W-1:0] fine,
  output logic [POS_W-1:0]  pos
);

  logic [POS_W-1:0] n_ext;
  logic [POS_W-1:0] base;

  assign n_ext = POS_W'(n_idx);

  always_comb begin
    if (step4) base = (n_ext << 2) + POS_W'(4);
    else       base = (n_ext << 1) + POS_W'(2);
    pos = base + POS_W'(fine);
  end

endmodule

// File: rtl/ceg_hwin.sv
`timescale 1ns/1ps
// Horizontal clock counter and window decision on its next value.
module ceg_hwin #(
  parameter int N_W    = 9,
  parameter int FINE_W = 2,
  localparam int CNT_W = N_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_ref,
  input  logic              step4,
  input  logic [N_W-1:0]    nmax,
  input  logic [N_W-1:0]    nr,
  input  logic [N_W-1:0]    nf,
  input  logic [FINE_W-1:0] fine,
  output logic              line_rise,
  output logic              h_win_nxt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             lr_q;
  logic [CNT_W-1:0] hcnt;
  logic [CNT_W-1:0] hcnt_nxt;
  logic [CNT_W-1:0] edge_pos [2];
  logic             cfg_ok;

  assign line_rise = line_ref & ~lr_q;

  always_comb begin
    if (line_rise)             hcnt_nxt = '0;
    else if (hcnt == CNT_MAX)  hcnt_nxt = hcnt;
    else                       hcnt_nxt = hcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_q <= 1'b0;
      hcnt <= '0;
    end else begin
      lr_q <= line_ref;
      hcnt <= hcnt_nxt;
    end
  end

  // Edge 0 is the rising edge, edge 1 the falling edge.
  for (genvar e = 0; e < 2; e++) begin : g_edge
    ceg_hpos #(.N_W(N_W), .FINE_W(FINE_W), .POS_W(CNT_W)) u_pos (
      .n_idx (e == 0 ? nr : nf),
      .step4 (step4),
      .fine  (fine),
      .pos   (edge_pos[e])
    );
  end

  assign cfg_ok = (nr < nmax) && (nf != '0) && (nf <= nmax) && (nr != nf);

  always_comb begin
    if (!cfg_ok)
      h_win_nxt = 1'b0;
    else if (nr < nf)
      h_win_nxt = (hcnt_nxt >= edge_pos[0]) && (hcnt_nxt < edge_pos[1]);
    else
      h_win_nxt = (hcnt_nxt >= edge_pos[0]) || (hcnt_nxt < edge_pos[1]);
  end

  // R2: the count restarts at the reference rise
  p_hcnt_restart_r2: assert property (@(posedge clk) disable iff (rst)
    line_rise |=> (hcnt == '0));

  // R2: between reference rises the count advances by one per clock
  p_hcnt_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (!line_rise && hcnt != CNT_MAX) |=> (hcnt == $past(hcnt) + 1'b1));

endmodule

// File: rtl/ceg_vwin.sv
`timescale 1ns/1ps
// Line counter, vertical window and alternating field flag.
module ceg_vwin #(
  parameter int V_W = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           field_ref,
  input  logic           line_rise,
  input  logic [V_W-1:0] nmax,
  input  logic [V_W-1:0] nr,
  input  logic [V_W-1:0] nf,
  output logic           v_win_nxt,
  output logic           fld_odd_nxt
);

  localparam logic [V_W-1:0] LCNT_MAX = {V_W{1'b1}};

  logic           fr_q;
  logic           field_rise;
  logic [V_W-1:0] lcnt;
  logic [V_W-1:0] lcnt_nxt;
  logic           fld_odd;
  logic           cfg_ok;

  assign field_rise = field_ref & ~fr_q;

  always_comb begin
    if (field_rise)                        lcnt_nxt = '0;
    else if (line_rise && lcnt != LCNT_MAX) lcnt_nxt = lcnt + 1'b1;
    else                                   lcnt_nxt = lcnt;
  end

  assign fld_odd_nxt = field_rise ? ~fld_odd : fld_odd;

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_q    <= 1'b0;
      lcnt    <= '0;
      fld_odd <= 1'b0;
    end else begin
      fr_q    <= field_ref;
      lcnt    <= lcnt_nxt;
      fld_odd <= fld_odd_nxt;
    end
  end

  assign cfg_ok = (nr >= V_W'(1)) && (nr < nmax) && (nf > V_W'(1)) &&
                  (nf <= nmax) && (nr < nf);

  assign v_win_nxt = cfg_ok && (lcnt_nxt >= nr) && (lcnt_nxt < nf);

  // R7: the line index restarts at the field reference rise
  p_lcnt_restart_r7: assert property (@(posedge clk) disable iff (rst)
    field_rise |=> (lcnt == '0));

  // R10: the field flag flips exactly on field reference rises
  p_fld_toggle_r10: assert property (@(posedge clk) disable iff (rst)
    field_rise |=> (fld_odd != $past(fld_odd)));

  p_fld_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !field_rise |=> $stable(fld_odd));

endmodule

// File: rtl/ceg_out.sv
`timescale 1ns/1ps
// Override priority and the single output register.
module ceg_out
  import ceg_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic still_en,
  input  logic ext_en,
  input  logic ext_we,
  input  logic prog_en,
  input  logic fld_odd_nxt,
  input  logic h_win_nxt,
  input  logic v_win_nxt,
  output logic mem_en
);

  en_src_e src;

  always_comb begin
    if (still_en)                    src = SRC_OFF;
    else if (ext_en)                 src = SRC_EXT;
    else if (prog_en && fld_odd_nxt) src = SRC_OFF;
    else                             src = SRC_WINDOW;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en <= 1'b0;
    end else begin
      case (src)
        SRC_EXT:    mem_en <= ext_we;
        SRC_WINDOW: mem_en <= h_win_nxt & v_win_nxt;
        default:    mem_en <= 1'b0;
      endcase
    end
  end

  p_still_low_r9: assert property (@(posedge clk) disable iff (rst)
    still_en |=> !mem_en);

  p_ext_follow_r11: assert property (@(posedge clk) disable iff (rst)
    (ext_en && !still_en) |=> (mem_en == $past(ext_we)));

  p_prog_gap_r10: assert property (@(posedge clk) disable iff (rst)
    (prog_en && !ext_en && fld_odd_nxt) |=> !mem_en);

  p_window_only_r2: assert property (@(posedge clk) disable iff (rst)
    (!still_en && !ext_en && !(h_win_nxt && v_win_nxt)) |=> !mem_en);

endmodule

// File: rtl/comp_enable_gen.sv
`timescale 1ns/1ps
module comp_enable_gen #(
  parameter int N_W    = 9,
  parameter int FINE_W = 2,
  parameter int V_W    = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_ref,
  input  logic              field_ref,
  input  logic              step4,
  input  logic [N_W-1:0]    h_nmax,
  input  logic [N_W-1:0]    h_rise_n,
  input  logic [N_W-1:0]    h_fall_n,
  input  logic [FINE_W-1:0] h_fine,
  input  logic [V_W-1:0]    v_nmax,
  input  logic [V_W-1:0]    v_rise_n,
  input  logic [V_W-1:0]    v_fall_n,
  input  logic              still_en,
  input  logic              prog_en,
  input  logic              ext_en,
  input  logic              ext_we,
  output logic              mem_en
);

  logic line_rise;
  logic h_win_nxt;
  logic v_win_nxt;
  logic fld_odd_nxt;

  ceg_hwin #(.N_W(N_W), .FINE_W(FINE_W)) u_hwin (
    .clk       (clk),
    .rst       (rst),
    .line_ref  (line_ref),
    .step4     (step4),
    .nmax      (h_nmax),
    .nr        (h_rise_n),
    .nf        (h_fall_n),
    .fine      (h_fine),
    .line_rise (line_rise),
    .h_win_nxt (h_win_nxt)
  );

  ceg_vwin #(.V_W(V_W)) u_vwin (
    .clk         (clk),
    .rst         (rst),
    .field_ref   (field_ref),
    .line_rise   (line_rise),
    .nmax        (v_nmax),
    .nr          (v_rise_n),
    .nf          (v_fall_n),
    .v_win_nxt   (v_win_nxt),
    .fld_odd_nxt (fld_odd_nxt)
  );

  ceg_out u_out (
    .clk         (clk),
    .rst         (rst),
    .still_en    (still_en),
    .ext_en      (ext_en),
    .ext_we      (ext_we),
    .prog_en     (prog_en),
    .fld_odd_nxt (fld_odd_nxt),
    .h_win_nxt   (h_win_nxt),
    .v_win_nxt   (v_win_nxt),
    .mem_en      (mem_en)
  );

  // R6: equal indices never open the window
  p_equal_idx_low_r6: assert property (@(posedge clk) disable iff (rst)
    (!ext_en && (h_rise_n == h_fall_n)) |=> !mem_en);

  // R8: a vertical pair with rise not below fall never opens the window
  p_vorder_low_r8: assert property (@(posedge clk) disable iff (rst)
    (!ext_en && (v_rise_n >= v_fall_n)) |=> !mem_en);

endmodule

// File: tb/comp_enable_gen_tb.sv
`timescale 1ns/1ps
module comp_enable_gen_tb_top;

  localparam int LINE = 64;
  localparam int LPF  = 6;

  logic       clk = 1'b0;
  logic       rst;
  logic       line_ref, field_ref, step4;
  logic [8:0] h_nmax, h_rise_n, h_fall_n, v_nmax, v_rise_n, v_fall_n;
  logic [1:0] h_fine;
  logic       still_en, prog_en, ext_en, ext_we;
  logic       mem_en;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;
  int m_k, m_line;
  bit m_lr, m_fr, m_odd, exp_en;

  always #2.5 clk = ~clk;

  comp_enable_gen dut_i (
    .clk(clk), .rst(rst), .line_ref(line_ref), .field_ref(field_ref),
    .step4(step4), .h_nmax(h_nmax), .h_rise_n(h_rise_n), .h_fall_n(h_fall_n),
    .h_fine(h_fine), .v_nmax(v_nmax), .v_rise_n(v_rise_n), .v_fall_n(v_fall_n),
    .still_en(still_en), .prog_en(prog_en), .ext_en(ext_en), .ext_we(ext_we),
    .mem_en(mem_en)
  );

  function automatic bit hwin_f(int k);
    int nr = int'(h_rise_n);
    int nf = int'(h_fall_n);
    int nm = int'(h_nmax);
    int st = step4 ? 4 : 2;
    int r  = st * nr + st + int'(h_fine);
    int f  = st * nf + st + int'(h_fine);
    if (!(nr < nm && nf != 0 && nf <= nm && nr != nf)) return 1'b0;
    if (nr < nf) return (k >= r) && (k < f);
    return (k >= r) || (k < f);
  endfunction

  function automatic bit vwin_f(int l);
    int nr = int'(v_rise_n);
    int nf = int'(v_fall_n);
    int nm = int'(v_nmax);
    if (!(nr >= 1 && nr < nm && nf > 1 && nf <= nm && nr < nf)) return 1'b0;
    return (l >= nr) && (l < nf);
  endfunction

  task automatic check(string req, bit expv);
    tests++;
    if (mem_en !== expv) begin
      fails++;
      $display("FAIL %s: mem_en=%0b expected %0b at cycle %0d", req, mem_en, expv, cyc);
    end
  endtask

  task automatic step(string req);
    bit lrise, frise;
    @(negedge clk);
    rst       = 1'b0;
    line_ref  = (cyc % LINE) < 2;
    field_ref = (cyc % (LINE * LPF)) < 3;
    ext_we    = ((cyc * 7) % 5) < 2;
    cyc++;
    lrise  = line_ref && !m_lr;
    frise  = field_ref && !m_fr;
    m_k    = lrise ? 0 : m_k + 1;
    m_line = frise ? 0 : (lrise ? m_line + 1 : m_line);
    m_odd  = m_odd ^ frise;
    m_lr   = line_ref;
    m_fr   = field_ref;
    if (still_en)                exp_en = 1'b0;
    else if (ext_en)             exp_en = ext_we;
    else if (prog_en && m_odd)   exp_en = 1'b0;
    else                         exp_en = hwin_f(m_k) && vwin_f(m_line);
    @(posedge clk);
    #1;
    check(req, exp_en);
  endtask

  task automatic run(int n, string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; line_ref = 1'b0; field_ref = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", 1'b0);
    m_k = 0; m_line = 0; m_lr = 0; m_fr = 0; m_odd = 0; cyc = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; line_ref = 0; field_ref = 0; step4 = 0; h_fine = 0;
    h_nmax = 9'd3; h_rise_n = 9'd0; h_fall_n = 9'd3;
    v_nmax = 9'd5; v_rise_n = 9'd1; v_fall_n = 9'd4;
    still_en = 0; prog_en = 0; ext_en = 0; ext_we = 0;

    do_reset();

    // Horizontal sweep: R2, R3, R4, R5, R6
    for (int s = 0; s < 2; s++)
      for (int nr = 0; nr < 4; nr++)
        for (int nf = 0; nf < 5; nf++)
          for (int fd = 0; fd < 4; fd++) begin
            string req;
            bit bad;
            step4 = s[0]; h_rise_n = 9'(nr); h_fall_n = 9'(nf); h_fine = 2'(fd);
            bad = !(nr < 3 && nf != 0 && nf <= 3 && nr != nf);
            if (bad)          req = "R6";
            else if (nr > nf) req = "R5";
            else if (fd != 0) req = "R4";
            else if (s == 1)  req = "R3";
            else              req = "R2";
            run(LINE * LPF, req);
          end

    // Vertical sweep: R7, R8
    step4 = 0; h_rise_n = 9'd0; h_fall_n = 9'd3; h_fine = 0;
    for (int vr = 0; vr < 4; vr++)
      for (int vf = 0; vf < 6; vf++) begin
        bit ok;
        v_rise_n = 9'(vr); v_fall_n = 9'(vf);
        ok = vr >= 1 && vr < 5 && vf > 1 && vf <= 5 && vr < vf;
        run(2 * LINE * LPF, ok ? "R7" : "R8");
      end

    // Progressive scan: R10
    v_rise_n = 9'd1; v_fall_n = 9'd5;
    do_reset();
    prog_en = 1;
    run(4 * LINE * LPF, "R10");
    prog_en = 0;

    // Still picture overrides external and window: R9
    still_en = 1; ext_en = 1;
    run(LINE * LPF, "R9");
    ext_en = 0;
    run(LINE * LPF, "R9");
    still_en = 0;

    // External mode, settings ignored: R11
    ext_en = 1;
    run(LINE * LPF, "R11");
    h_rise_n = 9'd2; h_fall_n = 9'd2; v_rise_n = 9'd0; h_fine = 2'd3; step4 = 1;
    run(LINE * LPF, "R11");
    prog_en = 1;
    run(2 * LINE * LPF, "R11");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule